// File: doc/BRIEF.md
# Program-Memory Table Pointer and Latch Unit

This unit keeps a 22-bit byte pointer into program memory together with an 8-bit data latch, and carries out table transfers between them and the memory system. A command selects a transfer direction (read or write) and one of four pointer-update modes. A read asks the program-memory port for the byte at the pointer and loads the returned byte into the latch. A write does not touch the flash array. It hands the latch byte and the pointer to the write holding buffer through a separate request port.

Pointer arithmetic works only on the low 21 bits, which cover a 2 MB byte-addressed program space. Bit 21 selects the configuration and identification area, and stepping never changes it. Software reaches the pointer as three byte registers and the latch as a fourth, all through one byte-wide access port. Both memory-side ports use a request held until acknowledge. While a transfer is pending the unit reports busy and ignores new commands and register writes.

Top module: `table_ptr_unit`

## Requirements
- R1: After reset the pointer and the latch are zero, and busy, mem_rd_req and wbuf_req are low.
- R2: reg_sel selects the byte register: 0 = pointer bits 7:0, 1 = pointer bits 15:8, 2 = pointer bits 21:16, 3 = latch. reg_rdata shows the selected byte combinationally. Selection 2 reads bits 7:6 as zero, and a write to it drops those bits. A register write takes effect at the clock edge that samples reg_wr_en, provided the unit is idle and cmd_valid is low.
- R3: cmd_mode 0 makes the access at the pointer and leaves the pointer unchanged.
- R4: cmd_mode 1 makes the access at the current pointer and adds one to the pointer at the edge that samples the acknowledge.
- R5: cmd_mode 2 makes the access at the current pointer and subtracts one from the pointer at the edge that samples the acknowledge.
- R6: cmd_mode 3 adds one to the pointer at the edge that accepts the command, and the access uses the incremented address.
- R7: Every increment and decrement wraps within pointer bits 20:0 and keeps bit 21 unchanged.
- R8: A read (cmd_write = 0) raises mem_rd_req from the cycle after acceptance, with mem_rd_addr equal to all 22 access-address bits. The latch takes mem_rd_data at the edge that samples mem_rd_ack.
- R9: A write (cmd_write = 1) raises wbuf_req, with wbuf_addr set to the access address and wbuf_data set to the latch value at acceptance. It never raises mem_rd_req and leaves the latch unchanged.
- R10: busy is high from the accepting edge until the edge that samples the acknowledge. cmd_valid and register writes are ignored while busy. In an idle cycle a command takes priority over a register write.
- R11: While busy, exactly one of mem_rd_req and wbuf_req is high, and its address and data stay constant until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_write | input | 1 | 1 = table write, 0 = table read |
| cmd_mode | input | 2 | Pointer update mode (0 hold, 1 post-inc, 2 post-dec, 3 pre-inc) |
| busy | output | 1 | Transfer pending |
| reg_wr_en | input | 1 | Byte register write strobe |
| reg_sel | input | 2 | Byte register select |
| reg_wdata | input | 8 | Byte register write data |
| reg_rdata | output | 8 | Selected byte register |
| mem_rd_req | output | 1 | Program-memory read request |
| mem_rd_addr | output | 22 | Program-memory read byte address |
| mem_rd_ack | input | 1 | Read acknowledge, data valid |
| mem_rd_data | input | 8 | Byte read from program memory |
| wbuf_req | output | 1 | Holding-buffer write request |
| wbuf_addr | output | 22 | Holding-buffer write address |
| wbuf_data | output | 8 | Holding-buffer write byte |
| wbuf_ack | input | 1 | Holding-buffer acknowledge |

## Verification
A command sampled at edge k raises busy and the matching request right after edge k. A pre-increment moves the pointer at that same edge. The latch load and the post-mode pointer step happen at the edge that samples the acknowledge, and busy falls right after that edge. reg_rdata follows reg_sel with no delay. The bench advances a behavioural model at each rising edge and compares every output one nanosecond after the falling edge, when registers and combinational paths have settled. Directed checks read the pointer back through the byte registers only after busy has dropped.

// File: rtl/tblu_pkg.sv
package tblu_pkg;
  parameter int PTR_W  = 22;
  parameter int DATA_W = 8;
  parameter int SEL_W  = 2;
  localparam int LOW_W = PTR_W - 1;
  localparam int NUM_PTR_BYTES = (PTR_W + DATA_W - 1) / DATA_W;
  localparam int PAD_W = (1 << SEL_W) * DATA_W;

  typedef enum logic [1:0] {
    UPD_HOLD     = 2'd0,
    UPD_POST_INC = 2'd1,
    UPD_POST_DEC = 2'd2,
    UPD_PRE_INC  = 2'd3
  } upd_mode_e;

  // Step the low field by one, keep the space-select bit.
  function automatic logic [PTR_W-1:0] ptr_bump(input logic [PTR_W-1:0] p,
                                                input logic down);
    logic [LOW_W-1:0] lo;
    lo = p[LOW_W-1:0];
    lo = down ? (lo - 1'b1) : (lo + 1'b1);
    return {p[PTR_W-1], lo};
  endfunction

  // Address used by the access itself.
  function automatic logic [PTR_W-1:0] access_addr(input logic [PTR_W-1:0] p,
                                                   input upd_mode_e m);
    return (m == UPD_PRE_INC) ? ptr_bump(p, 1'b0) : p;
  endfunction

  // Pointer value after completion of a post-mode access.
  function automatic logic [PTR_W-1:0] post_next(input logic [PTR_W-1:0] p,
                                                 input upd_mode_e m);
    case (m)
      UPD_POST_INC: return ptr_bump(p, 1'b0);
      UPD_POST_DEC: return ptr_bump(p, 1'b1);
      default:      return p;
    endcase
  endfunction
endpackage

// File: rtl/tblu_ptr_file.sv
module tblu_ptr_file
  import tblu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              pre_load,
  input  logic              post_upd,
  input  upd_mode_e         post_mode,
  input  logic              lat_load,
  input  logic [DATA_W-1:0] lat_val,
  output logic [PTR_W-1:0]  ptr,
  output logic [DATA_W-1:0] latch
);
  localparam logic [SEL_W-1:0] SEL_LATCH = SEL_W'(NUM_PTR_BYTES);

  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [DATA_W-1:0] lat_q, lat_d;
  logic [PAD_W-1:0]  ptr_pad, wr_pad;
  logic              sel_is_latch, ptr_byte_wr, latch_byte_wr;

  assign sel_is_latch  = (reg_sel == SEL_LATCH);
  assign ptr_byte_wr   = reg_wr && !sel_is_latch;
  assign latch_byte_wr = reg_wr && sel_is_latch;

  always_comb begin
    ptr_pad = PAD_W'(ptr_q);
    wr_pad  = ptr_pad;
    wr_pad[reg_sel*DATA_W +: DATA_W] = reg_wdata;
  end

  always_comb begin
    if (pre_load)         ptr_d = ptr_bump(ptr_q, 1'b0);
    else if (post_upd)    ptr_d = post_next(ptr_q, post_mode);
    else if (ptr_byte_wr) ptr_d = wr_pad[PTR_W-1:0];
    else                  ptr_d = ptr_q;
  end

  always_comb begin
    if (lat_load)           lat_d = lat_val;
    else if (latch_byte_wr) lat_d = reg_wdata;
    else                    lat_d = lat_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      lat_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      lat_q <= lat_d;
    end
  end

  assign reg_rdata = sel_is_latch ? lat_q : ptr_pad[reg_sel*DATA_W +: DATA_W];
  assign ptr   = ptr_q;
  assign latch = lat_q;

  // R7
  space_bit_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_load || post_upd) |=> (ptr_q[PTR_W-1] == $past(ptr_q[PTR_W-1])));
endmodule

// File: rtl/tblu_seq.sv
module tblu_seq
  import tblu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  upd_mode_e         cmd_mode,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [DATA_W-1:0] latch,
  input  logic              mem_rd_ack,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic              wbuf_ack,
  output logic              busy,
  output logic              mem_rd_req,
  output logic              wbuf_req,
  output logic [PTR_W-1:0]  acc_addr,
  output logic [DATA_W-1:0] wbuf_data,
  output logic              cmd_accept,
  output logic              xfer_done,
  output logic              pre_load,
  output logic              post_upd,
  output upd_mode_e         post_mode,
  output logic              lat_load,
  output logic [DATA_W-1:0] lat_val
);
  logic              busy_q, wr_q;
  upd_mode_e         mode_q;
  logic [PTR_W-1:0]  addr_q;
  logic [DATA_W-1:0] data_q;

  assign cmd_accept = cmd_valid && !busy_q;
  assign xfer_done  = busy_q && (wr_q ? wbuf_ack : mem_rd_ack);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      mode_q <= UPD_HOLD;
      addr_q <= '0;
      data_q <= '0;
    end else if (cmd_accept) begin
      busy_q <= 1'b1;
      wr_q   <= cmd_write;
      mode_q <= cmd_mode;
      addr_q <= access_addr(ptr, cmd_mode);
      data_q <= latch;
    end else if (xfer_done) begin
      busy_q <= 1'b0;
    end
  end

  assign busy       = busy_q;
  assign mem_rd_req = busy_q && !wr_q;
  assign wbuf_req   = busy_q && wr_q;
  assign acc_addr   = addr_q;
  assign wbuf_data  = data_q;
  assign pre_load   = cmd_accept && (cmd_mode == UPD_PRE_INC);
  assign post_upd   = xfer_done && (mode_q == UPD_POST_INC || mode_q == UPD_POST_DEC);
  assign post_mode  = mode_q;
  assign lat_load   = xfer_done && !wr_q;
  assign lat_val    = mem_rd_data;

  // R11
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> $onehot({mem_rd_req, wbuf_req}));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !xfer_done) |=> (busy_q && $stable(acc_addr) && $stable(wbuf_data)));

  // R6
  preinc_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && cmd_mode == UPD_PRE_INC) |=> (acc_addr == ptr));
endmodule

// File: rtl/table_ptr_unit.sv
module table_ptr_unit
  import tblu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [1:0]        cmd_mode,
  output logic              busy,
  input  logic              reg_wr_en,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mem_rd_req,
  output logic [PTR_W-1:0]  mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              wbuf_req,
  output logic [PTR_W-1:0]  wbuf_addr,
  output logic [DATA_W-1:0] wbuf_data,
  input  logic              wbuf_ack
);
  logic [PTR_W-1:0]  ptr, acc_addr;
  logic [DATA_W-1:0] latch, lat_val;
  logic              cmd_accept, xfer_done, pre_load, post_upd, lat_load;
  logic              reg_wr_ok;
  upd_mode_e         post_mode;

  assign reg_wr_ok = reg_wr_en && !busy && !cmd_valid;

  tblu_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_write   (cmd_write),
    .cmd_mode    (upd_mode_e'(cmd_mode)),
    .ptr         (ptr),
    .latch       (latch),
    .mem_rd_ack  (mem_rd_ack),
    .mem_rd_data (mem_rd_data),
    .wbuf_ack    (wbuf_ack),
    .busy        (busy),
    .mem_rd_req  (mem_rd_req),
    .wbuf_req    (wbuf_req),
    .acc_addr    (acc_addr),
    .wbuf_data   (wbuf_data),
    .cmd_accept  (cmd_accept),
    .xfer_done   (xfer_done),
    .pre_load    (pre_load),
    .post_upd    (post_upd),
    .post_mode   (post_mode),
    .lat_load    (lat_load),
    .lat_val     (lat_val)
  );

  tblu_ptr_file u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr_ok),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pre_load  (pre_load),
    .post_upd  (post_upd),
    .post_mode (post_mode),
    .lat_load  (lat_load),
    .lat_val   (lat_val),
    .ptr       (ptr),
    .latch     (latch)
  );

  assign mem_rd_addr = acc_addr;
  assign wbuf_addr   = acc_addr;

  // R10
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_done) |=> ($stable(ptr) && $stable(latch)));

  // R9
  write_keeps_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wbuf_req && wbuf_ack) |=> $stable(latch));
endmodule

// File: tb/sim_table_ptr_unit.sv
`timescale 1ns/100ps
module sim_table_ptr_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [1:0] cmd_mode = 2'd0;
  logic busy;
  logic reg_wr_en = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata;
  logic mem_rd_req, wbuf_req;
  logic [21:0] mem_rd_addr, wbuf_addr;
  logic mem_rd_ack = 1'b0, wbuf_ack = 1'b0;
  logic [7:0] mem_rd_data = 8'd0, wbuf_data;

  int checks = 0, failures = 0;
  int rd_lat = 0, wr_lat = 0, rd_cnt = 0, wr_cnt = 0;
  logic [21:0] seen_addr = '0;

  // reference model state
  logic m_busy = 0, m_wr = 0;
  int   m_mode = 0;
  logic [21:0] m_ptr = '0, m_addr = '0;
  logic [7:0]  m_lat = '0, m_wdat = '0;

  always #2.5 clk = ~clk;

  table_ptr_unit u0 (.*);

  function automatic logic [7:0] dfun(input logic [21:0] a);
    return a[7:0] ^ {2'b00, a[21:16]} ^ 8'h5A;
  endfunction
  function automatic logic [21:0] m_inc(input logic [21:0] p);
    return (p & 22'h200000) | ((p + 22'd1) & 22'h1FFFFF);
  endfunction
  function automatic logic [21:0] m_dec(input logic [21:0] p);
    return (p & 22'h200000) | ((p + 22'h1FFFFF) & 22'h1FFFFF);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory-side responders
  always @(negedge clk) begin
    if (mem_rd_req) begin
      if (rd_cnt >= rd_lat) begin
        mem_rd_ack = 1'b1; mem_rd_data = dfun(mem_rd_addr); rd_cnt = 0;
      end else begin
        mem_rd_ack = 1'b0; rd_cnt++;
      end
    end else begin
      mem_rd_ack = 1'b0; rd_cnt = 0;
    end
    if (wbuf_req) begin
      if (wr_cnt >= wr_lat) begin wbuf_ack = 1'b1; wr_cnt = 0; end
      else begin wbuf_ack = 1'b0; wr_cnt++; end
    end else begin
      wbuf_ack = 1'b0; wr_cnt = 0;
    end
  end

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_wr = 0; m_mode = 0; m_ptr = '0; m_addr = '0; m_lat = '0; m_wdat = '0;
    end else if (m_busy) begin
      if (m_wr ? wbuf_ack : mem_rd_ack) begin
        if (!m_wr) m_lat = mem_rd_data;
        if (m_mode == 1) m_ptr = m_inc(m_ptr);
        else if (m_mode == 2) m_ptr = m_dec(m_ptr);
        m_busy = 0;
      end
    end else if (cmd_valid) begin
      m_mode = cmd_mode; m_wr = cmd_write; m_wdat = m_lat;
      if (cmd_mode == 2'd3) m_ptr = m_inc(m_ptr);
      m_addr = m_ptr;
      m_busy = 1;
    end else if (reg_wr_en) begin
      case (reg_sel)
        2'd0: m_ptr[7:0] = reg_wdata;
        2'd1: m_ptr[15:8] = reg_wdata;
        2'd2: m_ptr[21:16] = reg_wdata[5:0];
        default: m_lat = reg_wdata;
      endcase
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk("R10 busy", busy, m_busy);
      chk("R11 mem_rd_req", mem_rd_req, m_busy && !m_wr);
      chk("R11 wbuf_req", wbuf_req, m_busy && m_wr);
      if (m_busy && !m_wr) chk("R8 mem_rd_addr", mem_rd_addr, m_addr);
      if (m_busy && m_wr) begin
        chk("R9 wbuf_addr", wbuf_addr, m_addr);
        chk("R9 wbuf_data", wbuf_data, m_wdat);
      end
      chk("R2 reg_rdata", reg_rdata,
          (reg_sel == 2'd3) ? m_lat : 8'((m_ptr >> (8 * reg_sel)) & 22'hFF));
      if (mem_rd_req) seen_addr = mem_rd_addr;
      if (wbuf_req)   seen_addr = wbuf_addr;
    end
  end

  task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask
  task automatic set_ptr(input logic [21:0] p);
    wr_reg(2'd0, p[7:0]); wr_reg(2'd1, p[15:8]); wr_reg(2'd2, {2'b00, p[21:16]});
  endtask
  task automatic rd_reg(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk); reg_sel = s; #1 v = reg_rdata;
  endtask
  task automatic expect_ptr(input string tag, input logic [21:0] exp);
    logic [7:0] b0, b1, b2;
    rd_reg(2'd0, b0); rd_reg(2'd1, b1); rd_reg(2'd2, b2);
    chk(tag, {b2, b1, b0}, {2'b00, exp});
  endtask
  task automatic expect_latch(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    rd_reg(2'd3, v); chk(tag, v, exp);
  endtask
  task automatic do_cmd(input logic wr, input logic [1:0] mode);
    @(negedge clk); cmd_valid = 1'b1; cmd_write = wr; cmd_mode = mode;
    @(negedge clk); cmd_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk); #1;
    chk("R1 busy", busy, 0); chk("R1 mem_rd_req", mem_rd_req, 0); chk("R1 wbuf_req", wbuf_req, 0);
    expect_ptr("R1 pointer", 22'h0);
    expect_latch("R1 latch", 8'h00);

    // R2 upper byte keeps only 6 bits
    wr_reg(2'd2, 8'hFF);
    rd_reg(2'd2, v); chk("R2 upper readback", v, 8'h3F);
    set_ptr(22'h001234);
    expect_ptr("R2 pointer bytes", 22'h001234);

    // R3 hold, R8 read into latch
    do_cmd(1'b0, 2'd0);
    chk("R3 access addr", seen_addr, 22'h001234);
    expect_ptr("R3 pointer unchanged", 22'h001234);
    expect_latch("R8 latch loaded", dfun(22'h001234));

    // R4 post-increment with read latency
    rd_lat = 2;
    do_cmd(1'b0, 2'd1);
    chk("R4 access addr", seen_addr, 22'h001234);
    expect_ptr("R4 pointer", 22'h001235);

    // R5 post-decrement, R9 table write
    wr_reg(2'd3, 8'hC3);
    wr_lat = 1;
    do_cmd(1'b1, 2'd2);
    chk("R5 access addr", seen_addr, 22'h001235);
    expect_ptr("R5 pointer", 22'h001234);
    expect_latch("R9 latch unchanged", 8'hC3);

    // R6 pre-increment
    do_cmd(1'b0, 2'd3);
    chk("R6 access addr", seen_addr, 22'h001235);
    expect_ptr("R6 pointer", 22'h001235);

    // R7 wrap in low field, space bit kept
    set_ptr(22'h1FFFFF);
    do_cmd(1'b0, 2'd1);
    expect_ptr("R7 wrap up low space", 22'h000000);
    set_ptr(22'h3FFFFF);
    do_cmd(1'b1, 2'd3);
    chk("R7 preinc addr high space", seen_addr, 22'h200000);
    expect_ptr("R7 wrap up high space", 22'h200000);
    do_cmd(1'b0, 2'd2);
    expect_ptr("R7 wrap down high space", 22'h3FFFFF);
    expect_latch("R8 config space read", dfun(22'h200000));

    // R10 commands and register writes ignored while busy
    set_ptr(22'h000100);
    rd_lat = 3;
    @(negedge clk); cmd_valid = 1'b1; cmd_write = 1'b0; cmd_mode = 2'd1;
    @(negedge clk); cmd_valid = 1'b1; cmd_write = 1'b1; cmd_mode = 2'd2;
    reg_wr_en = 1'b1; reg_sel = 2'd0; reg_wdata = 8'hAA;
    @(negedge clk);
    @(negedge clk); cmd_valid = 1'b0; reg_wr_en = 1'b0;
    while (busy) @(negedge clk);
    expect_ptr("R10 pointer after ignored inputs", 22'h000101);
    expect_latch("R10 latch after ignored inputs", dfun(22'h000100));

    // R10 command wins over register write in an idle cycle
    rd_lat = 0;
    @(negedge clk); cmd_valid = 1'b1; cmd_write = 1'b0; cmd_mode = 2'd0;
    reg_wr_en = 1'b1; reg_sel = 2'd1; reg_wdata = 8'h77;
    @(negedge clk); cmd_valid = 1'b0; reg_wr_en = 1'b0;
    while (busy) @(negedge clk);
    expect_ptr("R10 priority", 22'h000101);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule